// File: doc/BRIEF.md
# Reset and Clock Startup Sequencer

This block decides when the processor core and the peripheral bus of a small microcontroller may run. It is clocked from the oscillator. It takes seven reset request lines: power-on, external pin, watchdog, illegal opcode, illegal address, USB and low-voltage. From these it produces an internal reset, a drive enable for an open-drain reset pin, and two bus-rate clock enables, one for the core and one for the peripherals. The bus runs at half the oscillator rate.

A power-on or low-voltage event holds everything dark for a fixed 4096 oscillator cycles, and the reset pin is pulled low for that time. The other sources only pulse the internal reset. Stop mode turns off both bus clocks. On a wake-up or a reset, the bus clocks restart after a recovery delay of 2048 or 4096 oscillator cycles. Wait mode turns off only the core clock. A single 13-bit counter times every one of these delays.

A sticky source register records which requests have occurred. A power-on reset clears it to the power-on bit alone.

Top module: `rst_clk_seq`

## Requirements
- R1: While the bus runs, `per_clk_en_o` is high on every second oscillator cycle and never on two cycles in a row. `cpu_clk_en_o` is high only in cycles where `per_clk_en_o` is high.
- R2: After `rst_ni` is released, `rst_pin_drive_o` and `cpu_rst_o` stay high and both enables stay low for exactly 4096 rising edges. The first `per_clk_en_o` pulse follows on edge 4097.
- R3: `lvi_i` sampled high in any state restarts the 4096-edge hold, with the pin driven, counted from the edge that samples it.
- R4: A watchdog, illegal-opcode, illegal-address or USB request seen in run or wait mode raises `cpu_rst_o` on the next edge, without driving the pin. `cpu_rst_o` stays high while the request is held and for one bus cycle (two edges) after it drops.
- R5: The low-active `ext_rst_ni` passes through two synchronizer flops. A one-cycle low pulse raises `cpu_rst_o` on the third edge after it was driven, and `cpu_rst_o` then follows the rule of R4.
- R6: `rst_src_o` bit map: 0 power-on, 1 external pin, 2 watchdog, 3 illegal opcode, 4 illegal address, 5 USB, 6 low-voltage. A bit is set by its request outside the power-on hold (the low-voltage bit at any time) and stays set. Asserting `rst_ni` makes the register 7'b0000001 at once.
- R7: `stop_req_i` in run mode stops both enables from the next edge. `stop_fast_i` is sampled only on that edge: 1 selects a 2048-cycle recovery delay and 0 selects a 4096-cycle delay.
- R8: While stopped, a `wake_i` sampled at edge w starts the recovery delay. The block returns to run mode at edge w+delay, and the first `per_clk_en_o` and `cpu_clk_en_o` pulse comes one edge later.
- R9: A R4-class request while stopped also starts the recovery delay. When the delay ends, `cpu_rst_o` is high for two edges, and then the block runs.
- R10: `wait_req_i` in run mode gates the core enable off from the next edge while peripheral pulses continue. `wake_i` restores the core enable on the following bus pulse.
- R11: When requests arrive together in run mode, the priority is: low-voltage, then the other reset sources, then stop, then wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin level, active low, asynchronous |
| wdog_i | input | 1 | Watchdog reset request |
| bad_op_i | input | 1 | Illegal opcode reset request |
| bad_addr_i | input | 1 | Illegal address reset request |
| usb_rst_i | input | 1 | USB reset request |
| lvi_i | input | 1 | Low-voltage reset request |
| stop_req_i | input | 1 | Enter stop mode |
| wait_req_i | input | 1 | Enter wait mode |
| wake_i | input | 1 | Interrupt or break wake-up |
| stop_fast_i | input | 1 | Recovery delay select: 1 gives 2048 cycles, 0 gives 4096 |
| rst_pin_drive_o | output | 1 | Pull the reset pin low |
| cpu_rst_o | output | 1 | Internal system reset |
| cpu_clk_en_o | output | 1 | Core bus-clock enable |
| per_clk_en_o | output | 1 | Peripheral bus-clock enable |
| rst_src_o | output | 7 | Sticky reset source flags |

## Verification
A corrupted sequencer state appears at the ports within one edge: the pin drive, the internal reset and the two enables are all decoded from it. A counter or terminal-select fault stays hidden until a delay ends, so every timeout is checked on the edge before it ends and on the edge where it ends: 4096 for the hold, 2048 and 4096 for recovery, and two edges for the short reset. A bus-phase fault shows as two adjacent enable pulses or as a first pulse one edge out of place. The checks compare exact cycle numbers to catch either.

// File: rtl/clk_rst_pkg.sv
package clk_rst_pkg;
  localparam int SRC_W = 7;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_RUN,
    ST_SHORT,
    ST_STOP,
    ST_RECOV,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/rst_src_ctl.sv
module rst_src_ctl
  import clk_rst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_rst_ni,
  input  logic             wdog_i,
  input  logic             bad_op_i,
  input  logic             bad_addr_i,
  input  logic             usb_i,
  input  logic             lvi_i,
  input  logic             accept_i,
  output logic             other_req_o,
  output logic             lvi_req_o,
  output logic [SRC_W-1:0] src_o
);
  localparam logic [SRC_W-1:0] LVI_ONLY = SRC_W'(1) << (SRC_W - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_req;
  logic [SRC_W-1:0]       req_v, set_mask, src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_rst_ni};
  end

  assign ext_req     = ~sync_q[SYNC_STAGES-1];
  assign req_v       = {lvi_i, usb_i, bad_addr_i, bad_op_i, wdog_i, ext_req, 1'b0};
  assign set_mask    = accept_i ? '1 : LVI_ONLY;
  assign other_req_o = |req_v[SRC_W-2:1];
  assign lvi_req_o   = lvi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_W'(1);
    else         src_q <= src_q | (req_v & set_mask);
  end

  assign src_o = src_q;

  for (genvar i = 0; i < SRC_W; i++) begin : g_sticky
    p_src_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_q[i] |=> src_q[i]);
  end
endmodule

// File: rtl/tmo_cnt.sv
module tmo_cnt #(
  parameter int CNT_W  = 13,
  parameter int MAX_M1 = 4095
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == term_i);

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_M1));
endmodule

// File: rtl/clk_en_gen.sv
module clk_en_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_run_i,
  input  logic cpu_run_i,
  output logic per_en_o,
  output logic cpu_en_o
);
  logic ph_q;

  // phase parks at 0 whenever the bus is dark
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= bus_run_i ? ~ph_q : 1'b0;
  end

  assign per_en_o = bus_run_i & ph_q;
  assign cpu_en_o = cpu_run_i & ph_q;

  p_half_rate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |=> !per_en_o);
  p_cpu_in_per_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |-> per_en_o);
endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq
  import clk_rst_pkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int POR_CYC     = 4096,
  parameter int STOP_SLOW   = 4096,
  parameter int STOP_FAST   = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_rst_ni,
  input  logic             wdog_i,
  input  logic             bad_op_i,
  input  logic             bad_addr_i,
  input  logic             usb_rst_i,
  input  logic             lvi_i,
  input  logic             stop_req_i,
  input  logic             wait_req_i,
  input  logic             wake_i,
  input  logic             stop_fast_i,
  output logic             rst_pin_drive_o,
  output logic             cpu_rst_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic [SRC_W-1:0] rst_src_o
);
  localparam int HOLD_CYC = 2;
  localparam int MAX_CYC  = (POR_CYC > STOP_SLOW) ? POR_CYC : STOP_SLOW;
  localparam logic [CNT_W-1:0] POR_M1  = CNT_W'(POR_CYC - 1);
  localparam logic [CNT_W-1:0] SLOW_M1 = CNT_W'(STOP_SLOW - 1);
  localparam logic [CNT_W-1:0] FAST_M1 = CNT_W'(STOP_FAST - 1);
  localparam logic [CNT_W-1:0] HOLD_M1 = CNT_W'(HOLD_CYC - 1);

  seq_state_e       state_q, state_d;
  logic             sel_fast_q, pend_q;
  logic             other_req, lvi_req, tmo_done, cnt_clr, cnt_en;
  logic [CNT_W-1:0] term;

  rst_src_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_rst_ni  (ext_rst_ni),
    .wdog_i      (wdog_i),
    .bad_op_i    (bad_op_i),
    .bad_addr_i  (bad_addr_i),
    .usb_i       (usb_rst_i),
    .lvi_i       (lvi_i),
    .accept_i    (state_q != ST_PWR),
    .other_req_o (other_req),
    .lvi_req_o   (lvi_req),
    .src_o       (rst_src_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWR:   if (!lvi_req && tmo_done) state_d = ST_RUN;
      ST_RUN: begin
        if (lvi_req)         state_d = ST_PWR;
        else if (other_req)  state_d = ST_SHORT;
        else if (stop_req_i) state_d = ST_STOP;
        else if (wait_req_i) state_d = ST_WAIT;
      end
      ST_SHORT: begin
        if (lvi_req)                     state_d = ST_PWR;
        else if (!other_req && tmo_done) state_d = ST_RUN;
      end
      ST_STOP: begin
        if (lvi_req)                  state_d = ST_PWR;
        else if (other_req || wake_i) state_d = ST_RECOV;
      end
      ST_RECOV: begin
        if (lvi_req)       state_d = ST_PWR;
        else if (tmo_done) state_d = (pend_q || other_req) ? ST_SHORT : ST_RUN;
      end
      ST_WAIT: begin
        if (lvi_req)        state_d = ST_PWR;
        else if (other_req) state_d = ST_SHORT;
        else if (wake_i)    state_d = ST_RUN;
      end
      default: state_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PWR;
      sel_fast_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && state_d == ST_STOP) sel_fast_q <= stop_fast_i;
      if (state_d != ST_RECOV)                     pend_q <= 1'b0;
      else if (other_req)                          pend_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PWR:   term = POR_M1;
      ST_RECOV: term = sel_fast_q ? FAST_M1 : SLOW_M1;
      default:  term = HOLD_M1;
    endcase
  end

  // counter restarts on every phase entry and while a hold is re-armed
  assign cnt_clr = (state_d != state_q)
                 || (state_q == ST_SHORT && other_req)
                 || (state_q == ST_PWR && lvi_req);
  assign cnt_en  = (state_q == ST_PWR) || (state_q == ST_SHORT) || (state_q == ST_RECOV);

  tmo_cnt #(.CNT_W(CNT_W), .MAX_M1(MAX_CYC - 1)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .term_i (term),
    .done_o (tmo_done)
  );

  clk_en_gen u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_run_i ((state_q == ST_RUN) || (state_q == ST_WAIT) || (state_q == ST_SHORT)),
    .cpu_run_i ((state_q == ST_RUN) || (state_q == ST_SHORT)),
    .per_en_o  (per_clk_en_o),
    .cpu_en_o  (cpu_clk_en_o)
  );

  assign rst_pin_drive_o = (state_q == ST_PWR);
  assign cpu_rst_o       = (state_q == ST_PWR) || (state_q == ST_SHORT);

  p_pin_dark_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_drive_o |-> !per_clk_en_o && !cpu_clk_en_o && cpu_rst_o);
  p_lvi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvi_i |=> rst_pin_drive_o);
  p_short_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && other_req && !lvi_i) |=> cpu_rst_o && !rst_pin_drive_o);
  p_stop_dark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && stop_req_i && !lvi_i && !other_req) |=> !per_clk_en_o);
endmodule

// File: tb/sim_rst_clk_seq.sv
module sim_rst_clk_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SIG_PIN = 0, SIG_RST = 1, SIG_CPU = 2, SIG_PER = 3, SIG_SRC = 4;

  typedef struct {
    int    cyc;
    int    sig;
    int    val;
    string tag;
  } exp_t;

  logic       clk = 1'b0, rst_ni = 1'b0, ext_rst_ni = 1'b1;
  logic       wdog = 1'b0, bad_op = 1'b0, bad_addr = 1'b0, usb = 1'b0, lvi = 1'b0;
  logic       stop_req = 1'b0, wait_req = 1'b0, wake = 1'b0, stop_fast = 1'b0;
  logic       pin, cpu_rst, cpu_en, per_en;
  logic [6:0] src;

  int   cyc = 0, checks = 0, errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_clk_seq u0 (
    .clk_i (clk), .rst_ni (rst_ni), .ext_rst_ni (ext_rst_ni),
    .wdog_i (wdog), .bad_op_i (bad_op), .bad_addr_i (bad_addr),
    .usb_rst_i (usb), .lvi_i (lvi), .stop_req_i (stop_req),
    .wait_req_i (wait_req), .wake_i (wake), .stop_fast_i (stop_fast),
    .rst_pin_drive_o (pin), .cpu_rst_o (cpu_rst), .cpu_clk_en_o (cpu_en),
    .per_clk_en_o (per_en), .rst_src_o (src)
  );

  function automatic int actual(int sig);
    case (sig)
      SIG_PIN: return int'(pin);
      SIG_RST: return int'(cpu_rst);
      SIG_CPU: return int'(cpu_en);
      SIG_PER: return int'(per_en);
      default: return int'(src);
    endcase
  endfunction

  task automatic expect_at(int at, int sig, int val, string tag);
    sb.push_back('{at, sig, val, tag});
  endtask

  // monitor: retire every expectation due this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc <= cyc) begin
        checks++;
        if (sb[i].cyc != cyc || actual(sb[i].sig) != sb[i].val) begin
          errors++;
          $display("FAIL %s sig%0d cyc %0d: actual %0d expected %0d",
                   sb[i].tag, sb[i].sig, cyc, actual(sb[i].sig), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align_hi();
    do @(negedge clk); while (!per_en);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    int b;
    // reset state
    step(2);
    b = cyc;
    expect_at(b + 1, SIG_PIN, 1, "R2 reset pin");
    expect_at(b + 1, SIG_PER, 0, "R2 reset per");
    expect_at(b + 1, SIG_SRC, 7'b0000001, "R6 reset src");
    step(3);
    rst_ni = 1'b1;
    b = cyc;
    expect_at(b + 4095, SIG_PIN, 1, "R2 hold end-1");
    expect_at(b + 4096, SIG_PIN, 0, "R2 hold release");
    expect_at(b + 4096, SIG_PER, 0, "R2 no early pulse");
    expect_at(b + 4097, SIG_PER, 1, "R2 first pulse");
    expect_at(b + 4098, SIG_PER, 0, "R1 alternate");
    expect_at(b + 4099, SIG_CPU, 1, "R1 cpu pulse");
    drain();

    // wait mode
    align_hi();
    wait_req = 1'b1; b = cyc;
    expect_at(b + 1, SIG_CPU, 0, "R10 cpu gated");
    expect_at(b + 2, SIG_PER, 1, "R10 per runs");
    expect_at(b + 2, SIG_CPU, 0, "R10 cpu still gated");
    step(1); wait_req = 1'b0;
    step(1); wake = 1'b1; b = cyc;
    expect_at(b + 2, SIG_CPU, 1, "R10 cpu back");
    step(1); wake = 1'b0;
    drain();

    // watchdog held three cycles
    align_hi();
    wdog = 1'b1; b = cyc;
    expect_at(b + 1, SIG_RST, 1, "R4 short start");
    expect_at(b + 1, SIG_PIN, 0, "R4 pin idle");
    expect_at(b + 1, SIG_SRC, 7'b0000101, "R6 wdog bit");
    expect_at(b + 4, SIG_RST, 1, "R4 extra bus cycle");
    expect_at(b + 5, SIG_RST, 0, "R4 release");
    step(3); wdog = 1'b0;
    drain();

    // external pin pulse through synchronizer
    align_hi();
    ext_rst_ni = 1'b0; b = cyc;
    expect_at(b + 2, SIG_RST, 0, "R5 sync latency");
    expect_at(b + 2, SIG_SRC, 7'b0000101, "R5 not yet seen");
    expect_at(b + 3, SIG_RST, 1, "R5 reset seen");
    expect_at(b + 3, SIG_SRC, 7'b0000111, "R6 pin bit");
    expect_at(b + 5, SIG_RST, 0, "R5 release");
    step(1); ext_rst_ni = 1'b1;
    drain();

    // stop, fast select sampled at entry then changed
    stop_req = 1'b1; stop_fast = 1'b1; b = cyc;
    expect_at(b + 1, SIG_PER, 0, "R7 stop dark");
    expect_at(b + 3, SIG_PER, 0, "R7 stop dark 2");
    expect_at(b + 3, SIG_CPU, 0, "R7 cpu dark");
    step(1); stop_req = 1'b0; stop_fast = 1'b0;
    step(6); wake = 1'b1; b = cyc;
    expect_at(b + 2049, SIG_PER, 0, "R8 fast delay end-1");
    expect_at(b + 2050, SIG_PER, 1, "R8 fast resume");
    expect_at(b + 2050, SIG_CPU, 1, "R8 fast cpu resume");
    step(1); wake = 1'b0;
    drain();

    // stop, slow select
    stop_req = 1'b1; stop_fast = 1'b0;
    step(1); stop_req = 1'b0;
    step(4); wake = 1'b1; b = cyc;
    expect_at(b + 2050, SIG_PER, 0, "R7 slow not fast");
    expect_at(b + 4097, SIG_PER, 0, "R8 slow delay end-1");
    expect_at(b + 4098, SIG_PER, 1, "R8 slow resume");
    step(1); wake = 1'b0;
    drain();

    // reset request while stopped
    stop_req = 1'b1; stop_fast = 1'b1;
    step(1); stop_req = 1'b0;
    step(4); usb = 1'b1; b = cyc;
    expect_at(b + 1, SIG_SRC, 7'b0100111, "R9 usb bit");
    expect_at(b + 2, SIG_RST, 0, "R9 no early reset");
    expect_at(b + 2048, SIG_RST, 0, "R9 delay end-1");
    expect_at(b + 2049, SIG_RST, 1, "R9 reset after delay");
    expect_at(b + 2050, SIG_RST, 1, "R9 reset second edge");
    expect_at(b + 2051, SIG_RST, 0, "R9 release");
    step(1); usb = 1'b0;
    drain();

    // priority: reset beats stop and wait
    bad_op = 1'b1; stop_req = 1'b1; wait_req = 1'b1; b = cyc;
    expect_at(b + 1, SIG_RST, 1, "R11 reset over stop");
    expect_at(b + 1, SIG_SRC, 7'b0101111, "R6 opcode bit");
    expect_at(b + 3, SIG_RST, 0, "R11 short release");
    step(1); bad_op = 1'b0; stop_req = 1'b0; wait_req = 1'b0;
    drain();

    // priority: stop beats wait
    align_hi();
    stop_req = 1'b1; wait_req = 1'b1; stop_fast = 1'b1; b = cyc;
    expect_at(b + 2, SIG_PER, 0, "R11 stop over wait");
    step(1); stop_req = 1'b0; wait_req = 1'b0;
    step(2); wake = 1'b1; b = cyc;
    expect_at(b + 2050, SIG_PER, 1, "R11 stop exit");
    step(1); wake = 1'b0;
    drain();

    // priority: low-voltage beats everything
    lvi = 1'b1; wdog = 1'b1; stop_req = 1'b1; b = cyc;
    expect_at(b + 1, SIG_PIN, 1, "R3 lvi hold");
    expect_at(b + 1, SIG_SRC, 7'b1101111, "R6 lvi bit");
    expect_at(b + 4096, SIG_PIN, 1, "R3 hold end-1");
    expect_at(b + 4097, SIG_PIN, 0, "R3 hold release");
    expect_at(b + 4098, SIG_PER, 1, "R11 run after lvi");
    step(1); lvi = 1'b0; wdog = 1'b0; stop_req = 1'b0;
    drain();

    // power-on clears flags
    rst_ni = 1'b0; b = cyc;
    expect_at(b + 1, SIG_SRC, 7'b0000001, "R6 por clears");
    expect_at(b + 1, SIG_PIN, 1, "R2 por pin");
    step(2); rst_ni = 1'b1; b = cyc;
    expect_at(b + 4096, SIG_PIN, 0, "R2 second release");
    expect_at(b + 4097, SIG_PER, 1, "R2 second pulse");
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected end before 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule